// File: doc/BRIEF.md
# Eight-Voice Key Start/Release Controller

This block holds the key registers of an eight-voice sound generator and decides when each voice starts or releases. A host writes bytes to one of four registers chosen by a two-bit index: key-on, key-off, end flags and a flags register. For every voice the block drives a one-clock start pulse and a one-clock release pulse, and it keeps a vector that shows which voices are currently keyed. Sample fetch, envelope shaping and mixing sit downstream and act only on these pulses.

A key-on request aimed at a voice whose key-off bit is set is not lost. It is held as a pending start and fires on a later key-off write that leaves that voice's bit clear. The playback engine reports the end of a voice's sample on `voice_end`, and that sets the voice's end flag. A write to the flags register with its top bit set is a soft reset. It mutes the output, disables echo writes and drops all key state.

Register index codes: 0 = key-on, 1 = key-off, 2 = end flags, 3 = flags. In the flags byte, bit 7 is soft reset, bit 6 is mute and bit 5 is echo-write disable. In every key byte, bit n belongs to voice n.

Top module: `voice_key_ctrl`

## Requirements
- R1: After reset the key-on, key-off and end-flag registers read 0, the flags register reads 0xC0, `keyed_o` is 0, no pulse is driven and `mute_o` is 1.
- R2: A key-on write with bit n set, while key-off bit n is clear, gives a start pulse for voice n in the cycle after the write. It also sets `keyed_o[n]` and clears end flag n. The key-on register stores the written byte.
- R3: A key-on write with bit n set, while key-off bit n is set, gives no start pulse for voice n and records a pending start.
- R4: A key-off write with bit n set, while voice n is keyed, gives a release pulse for voice n in the cycle after the write. It clears `keyed_o[n]`, key-on bit n and any pending start for voice n. The key-off register stores the written byte.
- R5: A key-off write with bit n set, while voice n is not keyed, gives no release pulse and leaves `keyed_o[n]` unchanged.
- R6: A key-off write with bit n clear, while a start is pending for voice n, gives a start pulse for voice n, sets `keyed_o[n]`, clears end flag n and clears the pending start. Several voices may start in the same cycle.
- R7: A pulse on `voice_end[n]` sets end flag n. A write to the end-flag register leaves it at 0 whatever the data. A same-cycle clear (that write, a start, or a soft reset) wins over a `voice_end` set.
- R8: A flags write with bit 7 clear stores the byte as written, and `mute_o` follows flags bit 6.
- R9: A flags write with bit 7 set stores 0x60 OR'd with the low five data bits. It clears the key-on, key-off and end-flag registers, the keyed vector and all pending starts, and gives a release pulse for every voice that was keyed.
- R10: Start and release pulses last exactly one clock, and no voice gets both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register index for writes (0 key-on, 1 key-off, 2 end flags, 3 flags) |
| wr_data | input | 8 | Write data |
| voice_end | input | 8 | Per-voice end-of-sample event from playback |
| rd_sel | input | 2 | Register index for read-back |
| rd_data | output | 8 | Read-back of the selected register |
| start_o | output | 8 | One-clock start pulse per voice |
| release_o | output | 8 | One-clock release pulse per voice |
| keyed_o | output | 8 | Keyed status per voice |
| mute_o | output | 1 | Mute control (flags bit 6) |

## Verification
The bench drives key-on writes into voices whose key-off bit is set, then clears the key-off bits, some singly and some together. A design that started those voices at once, or lost the pending start, would show a start pulse in the wrong cycle or none at all. It writes key-off to voices that are not keyed: a design that released them anyway would pulse `release_o`. It writes nonzero data to the end-flag register while `voice_end` fires. A design that stored the data, or let the event win, would read back nonzero. It also fires a soft reset with a start still pending, and a design that kept the pending state would start that voice on the next key-off write.

// File: rtl/voice_key_pkg.sv
package voice_key_pkg;
  localparam int unsigned NUM_VOICES = 8;
  localparam int unsigned SEL_W      = 2;

  localparam logic [SEL_W-1:0] SEL_KON   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_KOFF  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_ENDF  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_FLAGS = 2'd3;

  localparam int unsigned FLG_SRST_BIT = 7;
  localparam int unsigned FLG_MUTE_BIT = 6;
  localparam int unsigned FLG_ECHO_BIT = 5;
  localparam int unsigned FLG_LOW_W    = 5;

  localparam logic [7:0] FLAGS_RST_VAL = 8'hC0;
endpackage

// File: rtl/voice_key_lane.sv
// Key state of one voice: keyed, pending start, key-on/key-off/end bits.
module voice_key_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic kon_wr,
  input  logic koff_wr,
  input  logic endf_wr,
  input  logic soft_rst,
  input  logic d_bit,
  input  logic end_evt,
  output logic start_p,
  output logic release_p,
  output logic keyed,
  output logic kon,
  output logic koff,
  output logic endf
);
  logic pend;
  logic keyed_n, kon_n, koff_n, endf_n, pend_n, start_n, release_n;
  logic st_en;

  assign st_en = kon_wr | koff_wr | endf_wr | soft_rst | end_evt;

  always_comb begin
    keyed_n   = keyed;
    kon_n     = kon;
    koff_n    = koff;
    pend_n    = pend;
    endf_n    = endf | end_evt;
    start_n   = 1'b0;
    release_n = 1'b0;
    if (soft_rst) begin
      keyed_n   = 1'b0;
      kon_n     = 1'b0;
      koff_n    = 1'b0;
      pend_n    = 1'b0;
      endf_n    = 1'b0;
      release_n = keyed;
    end else if (kon_wr) begin
      kon_n = d_bit;
      if (d_bit) begin
        if (!koff) begin
          keyed_n = 1'b1;
          endf_n  = 1'b0;
          pend_n  = 1'b0;
          start_n = 1'b1;
        end else begin
          pend_n = 1'b1;
        end
      end
    end else if (koff_wr) begin
      koff_n = d_bit;
      if (d_bit) begin
        if (keyed) begin
          keyed_n   = 1'b0;
          kon_n     = 1'b0;
          pend_n    = 1'b0;
          release_n = 1'b1;
        end
      end else if (pend) begin
        pend_n  = 1'b0;
        keyed_n = 1'b1;
        endf_n  = 1'b0;
        start_n = 1'b1;
      end
    end else if (endf_wr) begin
      endf_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_p   <= 1'b0;
      release_p <= 1'b0;
    end else begin
      start_p   <= start_n;
      release_p <= release_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keyed <= 1'b0;
      kon   <= 1'b0;
      koff  <= 1'b0;
      endf  <= 1'b0;
      pend  <= 1'b0;
    end else if (st_en) begin
      keyed <= keyed_n;
      kon   <= kon_n;
      koff  <= koff_n;
      endf  <= endf_n;
      pend  <= pend_n;
    end
  end
endmodule

// File: rtl/voice_flags_reg.sv
// Flags register with soft-reset detection.
module voice_flags_reg
  import voice_key_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] data,
  output logic       soft_rst,
  output logic [7:0] flags_q
);
  logic [7:0] flags_n;

  assign soft_rst = wr & data[FLG_SRST_BIT];

  always_comb begin
    flags_n = flags_q;
    if (wr) begin
      if (data[FLG_SRST_BIT]) begin
        flags_n = '0;
        flags_n[FLG_MUTE_BIT] = 1'b1;
        flags_n[FLG_ECHO_BIT] = 1'b1;
        flags_n[FLG_LOW_W-1:0] = data[FLG_LOW_W-1:0];
      end else begin
        flags_n = data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flags_q <= FLAGS_RST_VAL;
    else if (wr) flags_q <= flags_n;
  end
endmodule

// File: rtl/voice_key_ctrl.sv
// Top: register decode, eight voice lanes, flags, read-back mux.
module voice_key_ctrl
  import voice_key_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [NUM_VOICES-1:0] wr_data,
  input  logic [NUM_VOICES-1:0] voice_end,
  input  logic [SEL_W-1:0]      rd_sel,
  output logic [NUM_VOICES-1:0] rd_data,
  output logic [NUM_VOICES-1:0] start_o,
  output logic [NUM_VOICES-1:0] release_o,
  output logic [NUM_VOICES-1:0] keyed_o,
  output logic                  mute_o
);
  logic wr_kon, wr_koff, wr_endf, wr_flags, soft_rst;
  logic [NUM_VOICES-1:0] kon_q, koff_q, end_flags;
  logic [7:0] flags_q;

  assign wr_kon   = wr_en && (wr_sel == SEL_KON);
  assign wr_koff  = wr_en && (wr_sel == SEL_KOFF);
  assign wr_endf  = wr_en && (wr_sel == SEL_ENDF);
  assign wr_flags = wr_en && (wr_sel == SEL_FLAGS);

  voice_flags_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_flags),
    .data    (wr_data),
    .soft_rst(soft_rst),
    .flags_q (flags_q)
  );

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_lane
    voice_key_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .kon_wr   (wr_kon),
      .koff_wr  (wr_koff),
      .endf_wr  (wr_endf),
      .soft_rst (soft_rst),
      .d_bit    (wr_data[v]),
      .end_evt  (voice_end[v]),
      .start_p  (start_o[v]),
      .release_p(release_o[v]),
      .keyed    (keyed_o[v]),
      .kon      (kon_q[v]),
      .koff     (koff_q[v]),
      .endf     (end_flags[v])
    );
  end

  assign mute_o = flags_q[FLG_MUTE_BIT];

  always_comb begin
    unique case (rd_sel)
      SEL_KON:  rd_data = kon_q;
      SEL_KOFF: rd_data = koff_q;
      SEL_ENDF: rd_data = end_flags;
      default:  rd_data = flags_q;
    endcase
  end
endmodule

// File: rtl/voice_key_ctrl_chk.sv
module voice_key_ctrl_chk
  import voice_key_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [SEL_W-1:0]      wr_sel,
  input logic [NUM_VOICES-1:0] wr_data,
  input logic [NUM_VOICES-1:0] start_o,
  input logic [NUM_VOICES-1:0] release_o,
  input logic [NUM_VOICES-1:0] keyed_o,
  input logic [NUM_VOICES-1:0] end_flags,
  input logic [7:0]            flags_q
);
  a_r10_no_start_and_release: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o & release_o) == '0);

  a_r2_start_leaves_keyed: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_o) |-> ((start_o & ~keyed_o) == '0));

  a_r4_release_leaves_unkeyed: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_o) |-> ((release_o & keyed_o) == '0));

  a_r5_release_needs_keyed: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_o) |-> ((release_o & ~$past(keyed_o)) == '0));

  a_r7_endf_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_ENDF) |=> (end_flags == '0));

  a_r8_flags_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_FLAGS && !wr_data[FLG_SRST_BIT]) |=> (flags_q == $past(wr_data)));

  a_r9_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_FLAGS && wr_data[FLG_SRST_BIT]) |=>
      (keyed_o == '0 && end_flags == '0 && flags_q[7:5] == 3'b011));
endmodule

bind voice_key_ctrl voice_key_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .start_o  (start_o),
  .release_o(release_o),
  .keyed_o  (keyed_o),
  .end_flags(end_flags),
  .flags_q  (flags_q)
);

// File: tb/tb_voice_key_ctrl.sv
module tb_voice_key_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [7:0] voice_end;
  logic [1:0] rd_sel;
  logic [7:0] rd_data, start_o, release_o, keyed_o;
  logic       mute_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  voice_key_ctrl dut (.*);

  typedef struct {
    int    due;
    logic [7:0] st;
    logic [7:0] rl;
    logic [7:0] ky;
    logic       mu;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [7:0] m_kon, m_koff, m_endf, m_keyed, m_pend, m_flags;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expectations that are due at this falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (start_o !== e.st || release_o !== e.rl || keyed_o !== e.ky || mute_o !== e.mu) begin
        n_bad++;
        $display("FAIL %s: start=%h rel=%h keyed=%h mute=%b expected start=%h rel=%h keyed=%h mute=%b",
                 e.tag, start_o, release_o, keyed_o, mute_o, e.st, e.rl, e.ky, e.mu);
      end
    end
  end

  task automatic push(input logic [7:0] st, input logic [7:0] rl, input string tag);
    exp_t e;
    e.due = cyc + 1; e.st = st; e.rl = rl; e.ky = m_keyed; e.mu = m_flags[6]; e.tag = tag;
    q.push_back(e);
  endtask

  // driver: one write cycle (with optional end events), then one idle cycle
  task automatic drive(input bit we, input logic [1:0] sel, input logic [7:0] d,
                       input logic [7:0] endm, input string tag);
    logic [7:0] st, rl;
    st = '0; rl = '0;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; voice_end = endm;
    m_endf = m_endf | endm;
    if (we && sel == 2'd3 && d[7]) begin
      rl = m_keyed;
      m_kon = '0; m_koff = '0; m_endf = '0; m_keyed = '0; m_pend = '0;
      m_flags = 8'h60 | {3'b000, d[4:0]};
    end else if (we && sel == 2'd3) begin
      m_flags = d;
    end else if (we && sel == 2'd0) begin
      m_kon = d;
      st = d & ~m_koff;
      m_pend = (m_pend & ~st) | (d & m_koff);
      m_keyed = m_keyed | st;
      m_endf = m_endf & ~st;
    end else if (we && sel == 2'd1) begin
      rl = d & m_keyed;
      st = ~d & m_pend;
      m_koff = d;
      m_keyed = (m_keyed & ~rl) | st;
      m_kon = m_kon & ~rl;
      m_pend = m_pend & ~rl & ~st;
      m_endf = m_endf & ~st;
    end else if (we && sel == 2'd2) begin
      m_endf = '0;
    end
    push(st, rl, tag);
    @(negedge clk);
    wr_en = 1'b0; voice_end = '0;
    push('0, '0, {tag, " idle (R10)"});
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d, input string tag);
    drive(1'b1, sel, d, 8'h00, tag);
  endtask

  task automatic check_rd(input logic [1:0] sel, input logic [7:0] exp_v, input string tag);
    @(negedge clk);
    rd_sel = sel;
    #1;
    n_chk++;
    if (rd_data !== exp_v) begin
      n_bad++;
      $display("FAIL %s: rd[%0d]=%h expected %h", tag, sel, rd_data, exp_v);
    end
  endtask

  task automatic check_all(input string tag);
    check_rd(2'd0, m_kon, tag);
    check_rd(2'd1, m_koff, tag);
    check_rd(2'd2, m_endf, tag);
    check_rd(2'd3, m_flags, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; voice_end = '0; rd_sel = '0;
    m_kon = '0; m_koff = '0; m_endf = '0; m_keyed = '0; m_pend = '0; m_flags = 8'hC0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    push('0, '0, "R1 reset outputs");
    check_all("R1 reset registers");

    // R7 end events set flags
    drive(1'b0, 2'd0, 8'h00, 8'hFF, "R7 voice_end sets");
    check_rd(2'd2, m_endf, "R7 end flags set");

    // R2 immediate start
    wr(2'd0, 8'h05, "R2 key-on immediate");
    check_all("R2 registers after key-on");

    // R5 key-off of unkeyed voice
    wr(2'd1, 8'h02, "R5 key-off unkeyed no release");

    // R3 deferred key-on
    wr(2'd0, 8'h06, "R3 key-on deferred for voice1");
    check_rd(2'd0, m_kon, "R3 key-on register");

    // R6 pending fires
    wr(2'd1, 8'h00, "R6 pending start fires");
    check_rd(2'd2, m_endf, "R6 end flag cleared");

    // R6 several voices at once
    wr(2'd1, 8'h30, "R5 key-off unkeyed voices 4,5");
    wr(2'd0, 8'h30, "R3 key-on deferred 4,5");
    wr(2'd1, 8'h00, "R6 two pending starts same cycle");

    // R4 release of keyed voice
    wr(2'd1, 8'h01, "R4 release keyed voice0");
    check_all("R4 registers after release");

    // R4 release clears pending: voice7 pending, then keyed voice? use voice3
    wr(2'd0, 8'h08, "R2 key-on voice3 while koff bit3 clear");
    wr(2'd1, 8'h88, "R4/R5 release voice3, voice7 unkeyed");
    wr(2'd0, 8'h80, "R3 key-on voice7 deferred");
    wr(2'd1, 8'h00, "R6 voice7 start");

    // R7 end-flag write while events arrive
    drive(1'b0, 2'd0, 8'h00, 8'h0F, "R7 end events");
    drive(1'b1, 2'd2, 8'hFF, 8'h08, "R7 end write with same-cycle event");
    check_rd(2'd2, 8'h00, "R7 end flags zero after write");

    // R8 plain flags writes
    wr(2'd3, 8'h25, "R8 flags unmute");
    check_rd(2'd3, 8'h25, "R8 flags stored");
    wr(2'd3, 8'h4A, "R8 flags mute");
    check_rd(2'd3, 8'h4A, "R8 flags stored mute");

    // R9 soft reset with a pending start outstanding
    wr(2'd1, 8'h40, "R5 key-off voice6 unkeyed");
    wr(2'd0, 8'h40, "R3 key-on voice6 deferred");
    drive(1'b0, 2'd0, 8'h00, 8'h01, "R7 end event voice0");
    wr(2'd3, 8'h93, "R9 soft reset");
    check_all("R9 registers after soft reset");
    wr(2'd1, 8'h00, "R9 pending dropped by soft reset");
    wr(2'd0, 8'h11, "R2 key-on after soft reset");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule